// File: doc/BRIEF.md
# Mode-Selectable Clock Divider Tree

This block turns one fast clock (nominally 200 MHz) and a separate test clock into the clock groups a system board needs: a CPU group, a stoppable PCI group plus one free-running PCI output, a 48 MHz-class group, a reference group and an interrupt-controller group. A three-bit mode input picks the behaviour. One code disables every output driver. Two codes run the tree from the fast clock with a CPU rate of 100 MHz or 66.67 MHz, while PCI stays at a third of 100 MHz. One code divides the test clock by fixed ratios, and the remaining codes are reserved.

In the active modes the CPU and PCI outputs come from one shared phase counter. Every PCI rising edge therefore lands on a CPU rising edge. The divide-by-three CPU rate keeps a 50% duty cycle by adding a falling-edge register. Each group has its own output-enable signal for an external tri-state pad. A change of mode code restarts every divider on the next clock edge, and the new mode applies from that edge.

Top module: `ckt_divtree`

## Requirements
- R1: With mode_sel = 3'b000, every output enable (cpu_oe, pci_oe, usb_oe, ref_oe, apic_oe) is 0 and every clock output is 0, starting from the fast_clk edge after the code is applied.
- R2: With mode_sel = 3'b111, the CPU outputs run at fast_clk/2 (high 1 period, low 1 period) and the PCI outputs run at fast_clk/6 (high 3 periods, low 3 periods).
- R3: With mode_sel = 3'b011, the CPU outputs run at fast_clk/3 with a high time of exactly 1.5 fast_clk periods, and the PCI outputs run at fast_clk/6 with a 50% duty cycle.
- R4: In both active modes (3'b011, 3'b111), every rising edge of the PCI outputs occurs at the same fast_clk edge as a rising edge of the CPU outputs.
- R5: The reserved codes 3'b001, 3'b010, 3'b101 and 3'b110 hold every clock output at 0 with every output enable at 1.
- R6: With mode_sel = 3'b100 (test), the CPU and 48 MHz-class outputs are test_clk/2, the PCI and free-running PCI outputs are test_clk/6, the reference and interrupt-controller outputs equal test_clk, and all enables are 1.
- R7: In both active modes the 48 MHz-class outputs are fast_clk/4, the reference and interrupt-controller outputs are fast_clk/14 with a 50% duty cycle, and the free-running PCI output has the PCI period.
- R8: On the first fast_clk rising edge that sees a new mode code, all dividers restart from phase 0, so the CPU and PCI outputs both go high at that edge.
- R9: While rst is high, all output enables and all clock outputs are 0.
- R10: All outputs within one group are identical at all times, and the free-running PCI output equals the PCI group while the PCI group runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| fast_clk | input | 1 | Fast synthesized source clock (nominally 200 MHz) |
| test_clk | input | 1 | Test clock, used only in test mode |
| rst | input | 1 | Synchronous active-high reset, applied in both clock domains |
| mode_sel | input | 3 | Mode code: 000 drivers off, 011 CPU at fast/3, 111 CPU at fast/2, 100 test, others reserved |
| cpu_o | output | N_CPU (4) | CPU clock group |
| cpu_oe | output | 1 | Driver enable for the CPU group |
| pci_o | output | N_PCI (7) | Stoppable PCI clock group |
| pcif_o | output | 1 | Free-running PCI clock |
| pci_oe | output | 1 | Driver enable for the PCI group and the free-running PCI output |
| usb_o | output | N_USB (2) | 48 MHz-class clock group |
| usb_oe | output | 1 | Driver enable for the 48 MHz-class group |
| ref_o | output | N_REF (3) | Reference clock group |
| ref_oe | output | 1 | Driver enable for the reference group |
| apic_o | output | N_APIC (2) | Interrupt-controller clock group |
| apic_oe | output | 1 | Driver enable for the interrupt-controller group |

## Verification
Two functions can fall on the same fast_clk edge: the restart caused by a mode change, and the coincident CPU/PCI rising edge that comes from the shared counter. The bench waits for the PCI output to fall, which places the phase counter in the middle of the PCI low half. It then changes the mode code on the next falling clock edge. Just after the following rising edge it requires both CPU and PCI to be high; without the restart, PCI would have stayed low. The edge-alignment rule is then checked separately in each active mode by watching for PCI rises that are not matched by a CPU rise in the same sampling interval.

// File: rtl/ckt_pkg.sv
package ckt_pkg;

  typedef enum logic [2:0] {
    MD_OFF    = 3'd0,
    MD_RSVD   = 3'd1,
    MD_CPU3   = 3'd2,
    MD_CPU2   = 3'd3,
    MD_TEST   = 3'd4
  } ckt_mode_e;

  // Full decode of the three select inputs.
  function automatic ckt_mode_e ckt_decode(input logic [2:0] code);
    case (code)
      3'b000:  return MD_OFF;
      3'b011:  return MD_CPU3;
      3'b111:  return MD_CPU2;
      3'b100:  return MD_TEST;
      default: return MD_RSVD;
    endcase
  endfunction

endpackage

// File: rtl/ckt_div_leg.sv
// Free-running fixed-ratio divider with 50% duty cycle. An odd ratio gets
// its extra half period from a falling-edge copy of the rising-edge output.
module ckt_div_leg #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic clk_o
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);
  localparam logic [W-1:0] HALF = W'(DIV / 2);

  logic [W-1:0] cnt;
  logic [W-1:0] cnt_nx;
  logic         hi_pos;

  always_comb begin
    if (restart || cnt == LAST) cnt_nx = '0;
    else                        cnt_nx = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      hi_pos <= 1'b0;
    end else begin
      cnt    <= cnt_nx;
      hi_pos <= (cnt_nx < HALF);
    end
  end

  generate
    if (DIV % 2 == 1) begin : g_odd
      logic hi_neg;
      always_ff @(negedge clk) begin
        if (rst) hi_neg <= 1'b0;
        else     hi_neg <= hi_pos;
      end
      assign clk_o = hi_pos | hi_neg;
    end else begin : g_even
      assign clk_o = hi_pos;
    end
  endgenerate

endmodule

// File: rtl/ckt_cpu_pci.sv
// CPU and PCI clocks from one shared phase counter of length PCI_DIV.
module ckt_cpu_pci #(
  parameter int PCI_DIV  = 6,
  parameter int CPU_DIV2 = 2,
  parameter int CPU_DIV3 = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic fast_cpu,   // 1: CPU ratio CPU_DIV2, 0: CPU ratio CPU_DIV3
  output logic cpu_o,
  output logic pci_o
);
  localparam int PW = $clog2(PCI_DIV);
  localparam logic [PW-1:0] LAST = PW'(PCI_DIV - 1);

  function automatic logic [PCI_DIV-1:0] phase_mask(input int d);
    logic [PCI_DIV-1:0] m;
    for (int p = 0; p < PCI_DIV; p++) m[p] = ((p % d) < (d / 2));
    return m;
  endfunction

  localparam logic [PCI_DIV-1:0] MASK_C2  = phase_mask(CPU_DIV2);
  localparam logic [PCI_DIV-1:0] MASK_C3  = phase_mask(CPU_DIV3);
  localparam logic [PCI_DIV-1:0] MASK_PCI = phase_mask(PCI_DIV);

  logic [PW-1:0] ph;
  logic [PW-1:0] ph_nx;
  logic          cpu_pos;
  logic          cpu_neg;
  logic          odd_q;

  always_comb begin
    if (restart || ph == LAST) ph_nx = '0;
    else                       ph_nx = ph + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph      <= '0;
      cpu_pos <= 1'b0;
      pci_o   <= 1'b0;
      odd_q   <= 1'b0;
    end else begin
      ph      <= ph_nx;
      cpu_pos <= fast_cpu ? MASK_C2[ph_nx] : MASK_C3[ph_nx];
      pci_o   <= MASK_PCI[ph_nx];
      odd_q   <= fast_cpu ? (CPU_DIV2 % 2 == 1) : (CPU_DIV3 % 2 == 1);
    end
  end

  // Half-period extension for odd CPU ratios.
  always_ff @(negedge clk) begin
    if (rst) cpu_neg <= 1'b0;
    else     cpu_neg <= cpu_pos & odd_q;
  end

  assign cpu_o = cpu_pos | cpu_neg;

endmodule

// File: rtl/ckt_divtree.sv
module ckt_divtree
  import ckt_pkg::*;
#(
  parameter int N_CPU    = 4,
  parameter int N_PCI    = 7,
  parameter int N_USB    = 2,
  parameter int N_REF    = 3,
  parameter int N_APIC   = 2,
  parameter int PCI_DIV  = 6,
  parameter int CPU_DIV2 = 2,
  parameter int CPU_DIV3 = 3,
  parameter int USB_DIV  = 4,
  parameter int REF_DIV  = 14,
  parameter int TST_CPU_DIV = 2,
  parameter int TST_PCI_DIV = 6,
  parameter int TST_USB_DIV = 2
) (
  input  logic              fast_clk,
  input  logic              test_clk,
  input  logic              rst,
  input  logic [2:0]        mode_sel,
  output logic [N_CPU-1:0]  cpu_o,
  output logic              cpu_oe,
  output logic [N_PCI-1:0]  pci_o,
  output logic              pcif_o,
  output logic              pci_oe,
  output logic [N_USB-1:0]  usb_o,
  output logic              usb_oe,
  output logic [N_REF-1:0]  ref_o,
  output logic              ref_oe,
  output logic [N_APIC-1:0] apic_o,
  output logic              apic_oe
);

  // Mode registers, one copy per clock domain.
  logic [2:0] fsel_q, tsel_q;
  ckt_mode_e  fmode_q, tmode_q;
  ckt_mode_e  mode_now;
  logic       f_restart, t_restart;

  assign mode_now  = ckt_decode(mode_sel);
  assign f_restart = (mode_sel != fsel_q);
  assign t_restart = (mode_sel != tsel_q);

  always_ff @(posedge fast_clk) begin
    if (rst) begin
      fsel_q  <= 3'b000;
      fmode_q <= MD_OFF;
    end else begin
      fsel_q  <= mode_sel;
      fmode_q <= mode_now;
    end
  end

  always_ff @(posedge test_clk) begin
    if (rst) begin
      tsel_q  <= 3'b000;
      tmode_q <= MD_OFF;
    end else begin
      tsel_q  <= mode_sel;
      tmode_q <= mode_now;
    end
  end

  // Fast-clock dividers.
  logic f_cpu, f_pci, f_usb, f_ref;

  ckt_cpu_pci #(
    .PCI_DIV (PCI_DIV),
    .CPU_DIV2(CPU_DIV2),
    .CPU_DIV3(CPU_DIV3)
  ) u_cpupci (
    .clk     (fast_clk),
    .rst     (rst),
    .restart (f_restart),
    .fast_cpu(mode_now == MD_CPU2),
    .cpu_o   (f_cpu),
    .pci_o   (f_pci)
  );

  ckt_div_leg #(.DIV(USB_DIV)) u_fusb (
    .clk(fast_clk), .rst(rst), .restart(f_restart), .clk_o(f_usb)
  );

  ckt_div_leg #(.DIV(REF_DIV)) u_fref (
    .clk(fast_clk), .rst(rst), .restart(f_restart), .clk_o(f_ref)
  );

  // Test-clock dividers.
  logic t_cpu, t_pci, t_usb;

  ckt_div_leg #(.DIV(TST_CPU_DIV)) u_tcpu (
    .clk(test_clk), .rst(rst), .restart(t_restart), .clk_o(t_cpu)
  );

  ckt_div_leg #(.DIV(TST_PCI_DIV)) u_tpci (
    .clk(test_clk), .rst(rst), .restart(t_restart), .clk_o(t_pci)
  );

  ckt_div_leg #(.DIV(TST_USB_DIV)) u_tusb (
    .clk(test_clk), .rst(rst), .restart(t_restart), .clk_o(t_usb)
  );

  // Output selection per group.
  logic f_act, t_act, drv_on;
  logic cpu_s, pci_s, usb_s, ref_s;

  assign f_act  = (fmode_q == MD_CPU3) || (fmode_q == MD_CPU2);
  assign t_act  = (tmode_q == MD_TEST);
  assign drv_on = (fmode_q != MD_OFF);

  always_comb begin
    if (f_act) begin
      cpu_s = f_cpu;
      pci_s = f_pci;
      usb_s = f_usb;
      ref_s = f_ref;
    end else if (t_act) begin
      cpu_s = t_cpu;
      pci_s = t_pci;
      usb_s = t_usb;
      ref_s = test_clk;
    end else begin
      cpu_s = 1'b0;
      pci_s = 1'b0;
      usb_s = 1'b0;
      ref_s = 1'b0;
    end
  end

  generate
    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
      assign cpu_o[i] = cpu_s;
    end
    for (genvar i = 0; i < N_PCI; i++) begin : g_pci
      assign pci_o[i] = pci_s;
    end
    for (genvar i = 0; i < N_USB; i++) begin : g_usb
      assign usb_o[i] = usb_s;
    end
    for (genvar i = 0; i < N_REF; i++) begin : g_ref
      assign ref_o[i] = ref_s;
    end
    for (genvar i = 0; i < N_APIC; i++) begin : g_apic
      assign apic_o[i] = ref_s;
    end
  endgenerate

  assign pcif_o  = pci_s;
  assign cpu_oe  = drv_on;
  assign pci_oe  = drv_on;
  assign usb_oe  = drv_on;
  assign ref_oe  = drv_on;
  assign apic_oe = drv_on;

endmodule

// File: rtl/ckt_divtree_chk.sv
module ckt_divtree_chk #(
  parameter int N_CPU  = 4,
  parameter int N_PCI  = 7,
  parameter int N_USB  = 2,
  parameter int N_REF  = 3,
  parameter int N_APIC = 2
) (
  input logic              fast_clk,
  input logic              rst,
  input logic [2:0]        mode_sel,
  input logic [N_CPU-1:0]  cpu_o,
  input logic              cpu_oe,
  input logic [N_PCI-1:0]  pci_o,
  input logic              pcif_o,
  input logic              pci_oe,
  input logic [N_USB-1:0]  usb_o,
  input logic              usb_oe,
  input logic [N_REF-1:0]  ref_o,
  input logic              ref_oe,
  input logic [N_APIC-1:0] apic_o,
  input logic              apic_oe
);

  logic all_oe_on, all_oe_off, all_low, sel_active, sel_rsvd;

  assign all_oe_on  = cpu_oe & pci_oe & usb_oe & ref_oe & apic_oe;
  assign all_oe_off = !(cpu_oe | pci_oe | usb_oe | ref_oe | apic_oe);
  assign all_low    = (cpu_o == '0) && (pci_o == '0) && !pcif_o &&
                      (usb_o == '0) && (ref_o == '0) && (apic_o == '0);
  assign sel_active = (mode_sel == 3'b011) || (mode_sel == 3'b111);
  assign sel_rsvd   = (mode_sel == 3'b001) || (mode_sel == 3'b010) ||
                      (mode_sel == 3'b101) || (mode_sel == 3'b110);

  // R9: reset disables every driver.
  a_r9_reset_off: assert property (@(posedge fast_clk)
    rst |=> all_oe_off);

  // R1: off code disables every driver.
  a_r1_off_code: assert property (@(posedge fast_clk) disable iff (rst)
    (mode_sel == 3'b000) |=> all_oe_off);

  // R5: reserved codes keep drivers on and clocks low.
  a_r5_rsvd_low: assert property (@(posedge fast_clk) disable iff (rst)
    (sel_rsvd && $past(mode_sel) == mode_sel && $past(mode_sel, 2) == mode_sel &&
     $past(mode_sel, 3) == mode_sel) |-> (all_low && all_oe_on));

  // R2: CPU toggles on every fast edge in the divide-by-two mode.
  a_r2_cpu_toggle: assert property (@(posedge fast_clk) disable iff (rst)
    (mode_sel == 3'b111 && $past(mode_sel) == 3'b111 && $past(mode_sel, 2) == 3'b111 &&
     !$past(rst) && !$past(rst, 2)) |-> (cpu_o[0] != $past(cpu_o[0])));

  // R4: a PCI rise always comes with a CPU rise.
  a_r4_pci_on_cpu: assert property (@(posedge fast_clk) disable iff (rst)
    (sel_active && $past(mode_sel) == mode_sel && $past(mode_sel, 2) == mode_sel &&
     !$past(rst) && $rose(pci_o[0])) |-> $rose(cpu_o[0]));

  // R6: test mode keeps drivers on.
  a_r6_test_oe: assert property (@(posedge fast_clk) disable iff (rst)
    (mode_sel == 3'b100 && $past(mode_sel) == 3'b100) |-> all_oe_on);

endmodule

bind ckt_divtree ckt_divtree_chk #(
  .N_CPU (N_CPU),
  .N_PCI (N_PCI),
  .N_USB (N_USB),
  .N_REF (N_REF),
  .N_APIC(N_APIC)
) u_chk (.*);

// File: tb/test_ckt_divtree.sv
module test_ckt_divtree;

  localparam int CLK_PERIOD  = 12;
  localparam int TCLK_PERIOD = 16;
  localparam int NROW = 3;
  // sel, cpu_per, cpu_hi, pci_per, pci_hi, usb_per, ref_per, ref_hi
  localparam int VEC [NROW][8] = '{
    '{3, 36, 18, 72, 36, 48, 168, 84},
    '{7, 24, 12, 72, 36, 48, 168, 84},
    '{4, 32, 16, 96, 48, 32,  16,  8}
  };

  logic       fast_clk = 1'b0;
  logic       test_clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] mode_sel = 3'b111;
  logic [3:0] cpu_o;
  logic       cpu_oe;
  logic [6:0] pci_o;
  logic       pcif_o, pci_oe;
  logic [1:0] usb_o;
  logic       usb_oe;
  logic [2:0] ref_o;
  logic       ref_oe;
  logic [1:0] apic_o;
  logic       apic_oe;

  int total = 0;
  int bad   = 0;

  initial forever #(CLK_PERIOD / 2) fast_clk = ~fast_clk;
  initial forever #(TCLK_PERIOD / 2) test_clk = ~test_clk;

  ckt_divtree i_ckt_divtree (
    .fast_clk(fast_clk), .test_clk(test_clk), .rst(rst), .mode_sel(mode_sel),
    .cpu_o(cpu_o), .cpu_oe(cpu_oe), .pci_o(pci_o), .pcif_o(pcif_o),
    .pci_oe(pci_oe), .usb_o(usb_o), .usb_oe(usb_oe), .ref_o(ref_o),
    .ref_oe(ref_oe), .apic_o(apic_o), .apic_oe(apic_oe)
  );

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic sig(input int idx);
    case (idx)
      0: return cpu_o[0];
      1: return pci_o[0];
      2: return pcif_o;
      3: return usb_o[0];
      4: return ref_o[0];
      default: return apic_o[0];
    endcase
  endfunction

  function automatic int oe_bits();
    return {27'd0, cpu_oe, pci_oe, usb_oe, ref_oe, apic_oe};
  endfunction

  function automatic logic grp_ok();
    return (cpu_o == {4{cpu_o[0]}}) && (pci_o == {7{pci_o[0]}}) &&
           (pcif_o == pci_o[0]) && (usb_o == {2{usb_o[0]}}) &&
           (ref_o == {3{ref_o[0]}}) && (apic_o == {2{apic_o[0]}});
  endfunction

  function automatic logic all_low();
    return (cpu_o == 0) && (pci_o == 0) && !pcif_o && (usb_o == 0) &&
           (ref_o == 0) && (apic_o == 0);
  endfunction

  // Align to an odd time: all clock edges fall on even times.
  task automatic align();
    @(posedge fast_clk);
    #1;
  endtask

  task automatic wait_lvl(input int idx, input logic v, inout int n);
    while (sig(idx) !== v && n < 3000) begin
      #2;
      n++;
    end
  endtask

  task automatic measure(input int idx, output int per, output int hi);
    int n, t0, t1, t2;
    n = 0;
    align();
    wait_lvl(idx, 1'b0, n);
    wait_lvl(idx, 1'b1, n);
    t0 = int'($time);
    wait_lvl(idx, 1'b0, n);
    t1 = int'($time);
    wait_lvl(idx, 1'b1, n);
    t2 = int'($time);
    if (n >= 3000) begin
      per = -1;
      hi  = -1;
    end else begin
      per = t2 - t0;
      hi  = t1 - t0;
    end
  endtask

  task automatic settle();
    repeat (10) @(posedge fast_clk);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int per, hi;
    string tag;
    logic ok;

    // R9: reset state
    repeat (10) @(posedge fast_clk);
    #1;
    chk(oe_bits() == 0, "R9 reset enables", oe_bits(), 0);
    chk(all_low(), "R9 reset clocks low", int'(cpu_o), 0);
    @(negedge fast_clk);
    rst = 1'b0;

    // Table walk over the running modes
    for (int r = 0; r < NROW; r++) begin
      case (r)
        0: tag = "R3";
        1: tag = "R2";
        default: tag = "R6";
      endcase
      @(negedge fast_clk);
      mode_sel = 3'(VEC[r][0]);
      settle();
      #1;
      chk(oe_bits() == 31, {tag, " enables on"}, oe_bits(), 31);
      measure(0, per, hi);
      chk(per == VEC[r][1], {tag, " cpu period"}, per, VEC[r][1]);
      chk(hi == VEC[r][2], {tag, " cpu high"}, hi, VEC[r][2]);
      measure(1, per, hi);
      chk(per == VEC[r][3], {tag, " pci period"}, per, VEC[r][3]);
      chk(hi == VEC[r][4], {tag, " pci high"}, hi, VEC[r][4]);
      measure(2, per, hi);
      chk(per == VEC[r][3], {tag, " R7 free pci period"}, per, VEC[r][3]);
      measure(3, per, hi);
      chk(per == VEC[r][5], {tag, " R7 usb period"}, per, VEC[r][5]);
      chk(hi == VEC[r][5] / 2, {tag, " R7 usb high"}, hi, VEC[r][5] / 2);
      measure(4, per, hi);
      chk(per == VEC[r][6], {tag, " R7 ref period"}, per, VEC[r][6]);
      chk(hi == VEC[r][7], {tag, " R7 ref high"}, hi, VEC[r][7]);
      measure(5, per, hi);
      chk(per == VEC[r][6], {tag, " R7 apic period"}, per, VEC[r][6]);
      // R10: group members identical
      ok = 1'b1;
      align();
      for (int k = 0; k < 200; k++) begin
        if (!grp_ok()) ok = 1'b0;
        #2;
      end
      chk(ok, {tag, " R10 groups equal"}, int'(ok), 1);
    end

    // R4: PCI rises only together with CPU rises, in both active modes
    for (int m = 0; m < 2; m++) begin
      logic pp, cp, fine;
      int rises;
      @(negedge fast_clk);
      mode_sel = (m == 0) ? 3'b011 : 3'b111;
      settle();
      align();
      pp = pci_o[0];
      cp = cpu_o[0];
      fine = 1'b1;
      rises = 0;
      for (int k = 0; k < 400; k++) begin
        #2;
        if (!pp && pci_o[0]) begin
          rises++;
          if (!(!cp && cpu_o[0])) fine = 1'b0;
        end
        pp = pci_o[0];
        cp = cpu_o[0];
      end
      chk(fine && rises > 3, "R4 pci edge on cpu edge", rises, 1);
    end

    // R8: restart in mid PCI low half, both directions
    for (int m = 0; m < 2; m++) begin
      int n;
      n = 0;
      align();
      wait_lvl(1, 1'b1, n);
      wait_lvl(1, 1'b0, n);
      @(negedge fast_clk);
      mode_sel = (m == 0) ? 3'b011 : 3'b111;
      @(posedge fast_clk);
      #1;
      chk(pci_o[0] == 1'b1, "R8 restart pci high", int'(pci_o[0]), 1);
      chk(cpu_o[0] == 1'b1, "R8 restart cpu high", int'(cpu_o[0]), 1);
      settle();
    end

    // R1: drivers off
    @(negedge fast_clk);
    mode_sel = 3'b000;
    settle();
    #1;
    chk(oe_bits() == 0, "R1 enables off", oe_bits(), 0);
    ok = 1'b1;
    for (int k = 0; k < 100; k++) begin
      if (!all_low()) ok = 1'b0;
      #2;
    end
    chk(ok, "R1 clocks low", int'(ok), 1);

    // R5: reserved codes
    for (int c = 0; c < 4; c++) begin
      logic [2:0] code;
      case (c)
        0: code = 3'b001;
        1: code = 3'b010;
        2: code = 3'b101;
        default: code = 3'b110;
      endcase
      @(negedge fast_clk);
      mode_sel = 3'b100;
      settle();
      @(negedge fast_clk);
      mode_sel = code;
      settle();
      #1;
      chk(oe_bits() == 31, "R5 reserved enables on", oe_bits(), 31);
      ok = 1'b1;
      for (int k = 0; k < 100; k++) begin
        if (!all_low()) ok = 1'b0;
        #2;
      end
      chk(ok, "R5 reserved clocks low", int'(code), 0);
    end

    // R9: reset again from a running mode
    @(negedge fast_clk);
    mode_sel = 3'b111;
    settle();
    @(negedge fast_clk);
    rst = 1'b1;
    repeat (3) @(posedge fast_clk);
    #1;
    chk(oe_bits() == 0, "R9 reset from run enables", oe_bits(), 0);
    chk(all_low(), "R9 reset from run clocks", int'(cpu_o), 0);

    finish_run();
  end

endmodule